// File: doc/BRIEF.md
# Bidirectional Byte-Wide Parallel Port

This block is an eight-bit general-purpose I/O port placed on a simple byte-wide register bus. Software controls it through two registers. The port latch holds the values that pins drive when they are outputs. The direction register chooses, bit by bit, whether a pin's tri-state driver is on. Each pad is presented as an output enable plus an output value, and the level seen on the pin comes back into the block through a separate input.

A read of the data address returns a per-bit mix. Pins set as outputs return the latch bit. Pins set as inputs return the pin level after a two-stage synchronizer. The latch accepts writes whatever the direction bits hold. Reset makes every pin an input, so software can load the latch first and then switch pins to outputs without a glitch.

Top module: `bidir_pport`

## Requirements
- R1: After reset every direction bit is 0, so `pin_oe` is 0x00. The latch is 0x00, so `pin_out` is 0x00. A direction-register read returns 0x00. A data read returns the synchronized pin levels.
- R2: `pin_oe[i]` equals direction bit i. A 1 turns pin i's driver on, and a 0 leaves the pin high-impedance as an input.
- R3: `pin_out[i]` always equals latch bit i. When direction bit i changes from 0 to 1, the pin drives the latch value it already holds, starting in the cycle after the direction write.
- R4: A write to offset 0x0 always loads the latch, including bits whose pins are inputs. The read value of those input bits does not change as a result.
- R5: A read of offset 0x0 returns, for each bit i, latch bit i when direction bit i is 1 and the synchronized pin level when it is 0.
- R6: The direction register is at offset 0x4. All eight of its bits can be written, and a read returns the stored value.
- R7: A read of any offset other than 0x0 and 0x4 returns 0x00. A write to such an offset changes neither register.
- R8: A pin level change is seen on a data read after exactly two rising clock edges. After one edge the read still shows the old level.
- R9: A write takes effect on the rising edge where `bus_wr_en` is 1. Before that edge the outputs and read data show the old state. Reads are combinational from `bus_addr`. Without a write, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; internally released in step with the clock |
| bus_addr | input | 4 | Register offset |
| bus_wr_en | input | 1 | Write strobe for the selected offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected offset |
| pin_in | input | 8 | Level present on each pad |
| pin_oe | output | 8 | Per-pin tri-state driver enable |
| pin_out | output | 8 | Per-pin value driven when enabled |

## Verification
A corrupted direction bit shows on `pin_oe` in the same cycle. It also shows as a wrong bit in a data read, because that bit's mux picks the wrong source. A wrong latch bit shows at once on `pin_out`, and it shows in data reads only for output pins. For that reason the bench compares pad outputs on every vector, not only read data. A synchronizer that is too short or too long is caught by sampling the data read one and two edges after a pin change.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } pport_sel_e;

endpackage

// File: rtl/pport_rst_sync.sv
module pport_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);

  logic [1:0] shf_q;
  logic [1:0] shf_d;

  always_comb begin
    shf_d = {shf_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shf_q <= 2'b00;
    else        shf_q <= shf_d;
  end

  assign rst_int_n = shf_q[1];

endmodule

// File: rtl/pport_decode.sv
module pport_decode
  import pport_pkg::*;
#(
  parameter int AW       = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 4
) (
  input  logic [AW-1:0] addr,
  output pport_sel_e    sel
);

  localparam logic [AW-1:0] DATA_A = AW'(DATA_OFS);
  localparam logic [AW-1:0] DIR_A  = AW'(DIR_OFS);

  always_comb begin
    if (addr == DATA_A)     sel = SEL_DATA;
    else if (addr == DIR_A) sel = SEL_DIR;
    else                    sel = SEL_NONE;
  end

endmodule

// File: rtl/pport_in_sync.sv
module pport_in_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);

  localparam int NST = (STAGES < 2) ? 2 : STAGES;

  logic [W-1:0] stg_q [NST];
  logic [W-1:0] stg_d [NST];

  always_comb begin
    stg_d[0] = pin_async;
  end

  for (genvar k = 1; k < NST; k++) begin : g_chain
    always_comb begin
      stg_d[k] = stg_q[k-1];
    end
  end

  for (genvar k = 0; k < NST; k++) begin : g_flop
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[k] <= '0;
      else        stg_q[k] <= stg_d[k];
    end
  end

  assign pin_sync = stg_q[NST-1];

endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  pport_sel_e   sel,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);

  logic         lat_en;
  logic         dir_en;
  logic [W-1:0] lat_d;
  logic [W-1:0] dir_d;

  always_comb begin
    lat_en = wr_en && (sel == SEL_DATA);
    dir_en = wr_en && (sel == SEL_DIR);
    lat_d  = lat_en ? wdata : lat_q;
    dir_d  = dir_en ? wdata : dir_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '0;
    end else begin
      lat_q <= lat_d;
      dir_q <= dir_d;
    end
  end

endmodule

// File: rtl/pport_rd_mux.sv
module pport_rd_mux
  import pport_pkg::*;
#(
  parameter int W = 8
) (
  input  pport_sel_e   sel,
  input  logic [W-1:0] lat,
  input  logic [W-1:0] dir,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] rdata
);

  logic [W-1:0] mix;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign mix[i] = dir[i] ? lat[i] : pin_sync[i];
  end

  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = mix;
      SEL_DIR:  rdata = dir;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/bidir_pport.sv
module bidir_pport
  import pport_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 4,
  parameter int DATA_OFS    = 0,
  parameter int DIR_OFS     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr_en,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_oe,
  output logic [WIDTH-1:0]  pin_out
);

  logic             rst_int_n;
  pport_sel_e       sel;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pin_sync;

  pport_rst_sync i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  pport_decode #(
    .AW       (ADDR_W),
    .DATA_OFS (DATA_OFS),
    .DIR_OFS  (DIR_OFS)
  ) i_decode (
    .addr (bus_addr),
    .sel  (sel)
  );

  pport_regs #(.W(WIDTH)) i_regs (
    .clk   (clk),
    .rst_n (rst_int_n),
    .sel   (sel),
    .wr_en (bus_wr_en),
    .wdata (bus_wdata),
    .lat_q (lat_q),
    .dir_q (dir_q)
  );

  pport_in_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) i_in_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .pin_async (pin_in),
    .pin_sync  (pin_sync)
  );

  pport_rd_mux #(.W(WIDTH)) i_rd_mux (
    .sel      (sel),
    .lat      (lat_q),
    .dir      (dir_q),
    .pin_sync (pin_sync),
    .rdata    (bus_rdata)
  );

  assign pin_oe  = dir_q;
  assign pin_out = lat_q;

endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
  parameter int W        = 8,
  parameter int AW       = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [W-1:0]  wdata,
  input logic [W-1:0]  rdata,
  input logic [W-1:0]  pin_oe,
  input logic [W-1:0]  pin_out
);

  localparam logic [AW-1:0] DATA_A = AW'(DATA_OFS);
  localparam logic [AW-1:0] DIR_A  = AW'(DIR_OFS);

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0) && (pin_out == '0)); // R1

  AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR_A) |=> pin_oe == $past(wdata)); // R2

  AST_PRELOAD_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DIR_A) |=> pin_out == $past(pin_out)); // R3

  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == DATA_A) |=> pin_out == $past(wdata)); // R4

  AST_DATA_MIX_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DATA_A) |-> ((rdata ^ pin_out) & pin_oe) == '0); // R5

  AST_DIR_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == DIR_A) |-> rdata == pin_oe); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != DATA_A && addr != DIR_A) |-> rdata == '0); // R7

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == DATA_A || addr == DIR_A)) |=> $stable(pin_oe) && $stable(pin_out)); // R9

endmodule

bind bidir_pport pport_chk #(
  .W        (WIDTH),
  .AW       (ADDR_W),
  .DATA_OFS (DATA_OFS),
  .DIR_OFS  (DIR_OFS)
) i_pport_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .addr    (bus_addr),
  .wr_en   (bus_wr_en),
  .wdata   (bus_wdata),
  .rdata   (bus_rdata),
  .pin_oe  (pin_oe),
  .pin_out (pin_out)
);

// File: tb/test_bidir_pport.sv
`timescale 1ns/1ps
module test_bidir_pport;

  localparam logic [3:0] A_DATA = 4'h0;
  localparam logic [3:0] A_DIR  = 4'h4;

  logic       clk;
  logic       rst_n;
  logic [3:0] bus_addr;
  logic       bus_wr_en;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_lvl;
  logic [7:0] pin_oe;
  logic [7:0] pin_out;
  logic [7:0] ext_val;

  logic [7:0] m_dir;
  logic [7:0] m_lat;
  int vectors;
  int miscompares;

  typedef struct {
    string      tag;
    bit         chk_rd;
    logic [7:0] rd;
    logic [7:0] oe;
    logic [7:0] out;
  } exp_t;

  exp_t sb_q[$];

  // pad model: an external driver owns the pin whenever the block's driver is off
  assign pin_lvl = (pin_oe & pin_out) | (~pin_oe & ext_val);

  bidir_pport i_bidir_pport (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr_en (bus_wr_en),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_lvl),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [7:0] exp_data();
    return (m_dir & m_lat) | (~m_dir & ext_val);
  endfunction

  task automatic push(input string tag, input bit chk_rd, input logic [7:0] rd);
    exp_t e;
    e.tag = tag; e.chk_rd = chk_rd; e.rd = rd; e.oe = m_dir; e.out = m_lat;
    sb_q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_wr_en = 1'b0;
    end
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_wr_en = 1'b0;
    bus_addr  = a;
    push(tag, 1'b1, exp);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr_en = 1'b1;
    push(tag, a == A_DIR, m_dir);          // old state visible before the edge (R9)
    @(negedge clk);
    bus_wr_en = 1'b0;
    if (a == A_DATA) m_lat = d;
    else if (a == A_DIR) m_dir = d;
    push(tag, a == A_DIR, m_dir);          // new state right after the edge
  endtask

  task automatic set_ext(input logic [7:0] v);
    @(negedge clk);
    ext_val = v;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
  endtask

  // monitor: compares queued expectations away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        vectors++;
        if (pin_oe !== e.oe) begin
          miscompares++;
          $display("FAIL %s pin_oe actual=%02h expected=%02h", e.tag, pin_oe, e.oe);
        end
        if (pin_out !== e.out) begin
          miscompares++;
          $display("FAIL %s pin_out actual=%02h expected=%02h", e.tag, pin_out, e.out);
        end
        if (e.chk_rd && bus_rdata !== e.rd) begin
          miscompares++;
          $display("FAIL %s rdata addr=%0h actual=%02h expected=%02h",
                   e.tag, bus_addr, bus_rdata, e.rd);
        end
      end
    end
  end

  // watchdog
  initial begin
    #400000;
    miscompares++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    vectors = 0; miscompares = 0;
    rst_n = 1'b0; bus_addr = A_DATA; bus_wr_en = 1'b0; bus_wdata = 8'h00;
    ext_val = 8'hA5; m_dir = 8'h00; m_lat = 8'h00;
    idle(4);
    rst_n = 1'b1;
    idle(5);

    // R1: reset state
    rd(A_DATA, exp_data(), "R1");
    rd(A_DIR, 8'h00, "R1");

    // R4: latch loads while all pins are inputs, reads still show pins
    wr(A_DATA, 8'h3C, "R4");
    idle(3);
    rd(A_DATA, exp_data(), "R4");

    // R3: enabling outputs drives the preloaded latch at once
    wr(A_DIR, 8'h0F, "R3");
    idle(3);
    rd(A_DATA, exp_data(), "R5");

    // R8: pin change visible after two edges, not one
    set_ext(8'h5A);
    begin
      logic [7:0] old_v;
      old_v = (m_dir & m_lat) | (~m_dir & 8'hA5);
      rd(A_DATA, old_v, "R8");
    end
    rd(A_DATA, exp_data(), "R8");

    // R4/R5: latch write with mixed directions
    wr(A_DATA, 8'hF0, "R4");
    idle(3);
    rd(A_DATA, exp_data(), "R5");

    // R2/R6: all outputs, readback of direction
    wr(A_DIR, 8'hFF, "R2");
    idle(3);
    rd(A_DATA, exp_data(), "R2");
    rd(A_DIR, 8'hFF, "R6");

    // R7: unmapped offsets read zero, writes have no effect
    wr(4'h8, 8'h77, "R7");
    wr(4'h2, 8'h11, "R7");
    rd(4'h8, 8'h00, "R7");
    rd(4'hC, 8'h00, "R7");
    rd(A_DIR, 8'hFF, "R7");
    rd(A_DATA, 8'hF0, "R7");

    // R2: outputs off again, pins return to external levels
    wr(A_DIR, 8'h00, "R2");
    idle(3);
    rd(A_DATA, exp_data(), "R2");

    // R5/R6: walking single output bit
    for (int i = 0; i < 8; i++) begin
      wr(A_DIR, 8'(1 << i), "R6");
      wr(A_DATA, 8'h96 ^ 8'(i * 37), "R5");
      idle(3);
      rd(A_DATA, exp_data(), "R5");
      rd(A_DIR, 8'(1 << i), "R6");
    end

    // R9: back-to-back writes, each visible one edge later
    wr(A_DATA, 8'h81, "R9");
    wr(A_DATA, 8'h42, "R9");
    wr(A_DIR, 8'hC3, "R9");
    idle(3);
    rd(A_DATA, exp_data(), "R9");

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    bus_addr = A_DIR;
    m_dir = 8'h00; m_lat = 8'h00;
    push("R1", 1'b1, 8'h00);
    idle(3);
    rst_n = 1'b1;
    idle(5);
    rd(A_DATA, exp_data(), "R1");
    rd(A_DIR, 8'h00, "R1");

    idle(2);
    wait (sb_q.size() == 0);
    @(negedge clk);
    #2;
    summary();
    $finish;
  end

endmodule